// File: doc/BRIEF.md
# MAC Interrupt Status and Soft-Reset Controller

This block keeps the interrupt side of an Ethernet MAC's register set together with its command register. Single-cycle event pulses from the transmit and receive DMA engines are collected into sticky status bits. Software clears those bits by writing ones. A per-bit enable mask turns them into two interrupt lines: the upper half-word of the status feeds the transmit line and the lower half-word feeds the receive line.

The command register holds the receive-on, accept-long-packet and transmit-on controls. It also holds a software-reset bit. Setting that bit starts a fixed-length reset sequence. For its whole length the block asserts a reset request to both DMA engines, and every register reads as zero. When the sequence ends, every register holds its default value again and the reset bit has cleared itself.

The register port is a plain word-addressed interface with separate write and read strobes and no back-pressure. A write lands at the clock edge where `wr_en` is high. A read returns its data on the cycle after `rd_en` and holds it until the next read.

Top module: `mac_irq_ctl`

## Requirements
- R1: After hardware reset the registers read as follows: command (word 0), enable (word 1) and status (word 2) read 0. Both descriptor-list start registers (words 3 and 4) read 0xFFFFFFFC. The FIFO threshold register (word 5) reads 0x00000101. Receive frame control (word 6) reads 0x00000800. The missed-packet count (word 7) reads 0x00007FFF. The MII address register (word 8) reads 0x00900000.
- R2: An event pulse at an implemented status position sets that status bit, and the bit stays set. The implemented positions are 0, 3, 4, 8, 9, 10, 11, 16, 18, 23 and 24. Pulses at every other position leave the status at 0 there.
- R3: Writing the status register (word 2) clears each bit written as 1 and leaves each bit written as 0. Writing 0xFFFF0000 clears only the transmit-side bits.
- R4: If an event and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R5: `irq_tx` is high when any of status bits 31:16 is set together with its matching enable bit. `irq_rx` does the same for bits 15:0. The enable register (word 1) is a plain 32-bit read/write register.
- R6: A read with `rd_en` returns the addressed word on the next cycle and holds it until the next read. Unmapped words read 0.
- R7: Writing word 0 with bit 24 set, while no reset is running, starts a software reset. `dma_rst_req` is then high for exactly 16 cycles, starting in the cycle after the write.
- R8: While the software reset runs, every read returns 0. Register writes and event pulses have no effect, and both interrupt lines stay low.
- R9: When the software reset ends, every register holds its R1 default. That includes the command register, whose bit 24 reads 0. Any other bits in the write that started the reset are dropped.
- R10: Command bit 0 drives `rx_on`, bit 1 drives `long_pkt_ok` and bit 8 drives `tx_on`. Each follows the stored value from the cycle after the write.
- R11: The configuration words 3 to 8 are plain read/write registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Word address of the read |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| evt_pulse | input | 32 | Single-cycle event pulses, one per status position |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rx | output | 1 | Receive interrupt line |
| dma_rst_req | output | 1 | Reset request to both DMA engines |
| rx_on | output | 1 | Receive enable from the command register |
| long_pkt_ok | output | 1 | Accept-long-packet control from the command register |
| tx_on | output | 1 | Transmit enable from the command register |

## Verification
If a status bit were lost or stuck, it would show on the matching interrupt line in the cycle after the event, provided its enable is set. It would also show in the next status read. A reset counter that is off by one would stretch or cut `dma_rst_req` by one cycle, and the bench sees that on the very next edge. The bench's reference model tracks status, enable, configuration and the reset countdown every cycle. Any wrong half-word split, write-versus-event priority or default value therefore shows up as a mismatch on `rd_data` or on an interrupt line within one cycle.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 4;

  // word addresses
  localparam logic [AW-1:0] A_CMD  = 4'd0;
  localparam logic [AW-1:0] A_IEN  = 4'd1;
  localparam logic [AW-1:0] A_IST  = 4'd2;
  localparam int unsigned   CFG_BASE = 3;
  localparam int unsigned   CFG_N    = 6;

  // command bits
  localparam int unsigned CMD_RXON = 0;
  localparam int unsigned CMD_LONG = 1;
  localparam int unsigned CMD_TXON = 8;
  localparam int unsigned CMD_SRST = 24;

  // implemented status positions
  localparam int unsigned ST_RXI   = 0;
  localparam int unsigned ST_PTL   = 3;
  localparam int unsigned ST_RXG   = 4;
  localparam int unsigned ST_MFL   = 8;
  localparam int unsigned ST_EARLY = 9;
  localparam int unsigned ST_RDU   = 10;
  localparam int unsigned ST_RBE   = 11;
  localparam int unsigned ST_TXI   = 16;
  localparam int unsigned ST_TXC   = 18;
  localparam int unsigned ST_TDU   = 23;
  localparam int unsigned ST_TBE   = 24;

  localparam logic [DW-1:0] EVT_MASK =
    (32'd1 << ST_RXI) | (32'd1 << ST_PTL) | (32'd1 << ST_RXG) |
    (32'd1 << ST_MFL) | (32'd1 << ST_EARLY) | (32'd1 << ST_RDU) |
    (32'd1 << ST_RBE) | (32'd1 << ST_TXI) | (32'd1 << ST_TXC) |
    (32'd1 << ST_TDU) | (32'd1 << ST_TBE);

  // defaults of config words 3..8, lowest word in the lowest slice
  localparam logic [CFG_N*DW-1:0] CFG_DEFAULTS = {
    32'h0090_0000,   // word 8: MII address
    32'h0000_7FFF,   // word 7: missed-packet count
    32'h0000_0800,   // word 6: receive frame control
    32'h0000_0101,   // word 5: FIFO threshold
    32'hFFFF_FFFC,   // word 4: receive list start
    32'hFFFF_FFFC    // word 3: transmit list start
  };
endpackage

// File: rtl/mac_srst_seq.sv
module mac_srst_seq #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (start)      cnt_q <= LOAD;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/mac_cfg_bank.sv
module mac_cfg_bank #(
  parameter int unsigned N  = 6,
  parameter int unsigned DW = 32,
  parameter logic [N*DW-1:0] DEFAULTS = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [N-1:0]    wr_sel,
  input  logic [DW-1:0]   wr_data,
  output logic [N*DW-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_word
    localparam logic [DW-1:0] DEF = DEFAULTS[i*DW +: DW];
    logic [DW-1:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         r_q <= DEF;
      else if (clr)       r_q <= DEF;
      else if (wr_sel[i]) r_q <= wr_data;
    end
    assign q[i*DW +: DW] = r_q;
  end
endmodule

// File: rtl/mac_isr_status.sv
module mac_isr_status #(
  parameter int unsigned DW = 32,
  parameter logic [DW-1:0] MASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [DW-1:0] evt,
  input  logic          st_we,
  input  logic          en_we,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] status_q,
  output logic [DW-1:0] enable_q,
  output logic          irq_tx,
  output logic          irq_rx
);
  localparam int unsigned HALF = DW / 2;

  logic [DW-1:0] w1c;
  logic [DW-1:0] live;

  assign w1c = st_we ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   status_q <= '0;
    else if (clr) status_q <= '0;
    else          status_q <= (status_q & ~w1c) | (evt & MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     enable_q <= '0;
    else if (clr)   enable_q <= '0;
    else if (en_we) enable_q <= wr_data;
  end

  assign live   = status_q & enable_q;
  assign irq_tx = |live[DW-1:HALF];
  assign irq_rx = |live[HALF-1:0];
endmodule

// File: rtl/mac_irq_ctl.sv
module mac_irq_ctl
  import mac_irq_pkg::*;
#(
  parameter int unsigned SRST_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] evt_pulse,
  output logic          irq_tx,
  output logic          irq_rx,
  output logic          dma_rst_req,
  output logic          rx_on,
  output logic          long_pkt_ok,
  output logic          tx_on
);
  localparam logic [DW-1:0] CMD_KEEP = ~(32'd1 << CMD_SRST);

  logic             busy, sr_start, clr, wr_ok;
  logic [DW-1:0]    cmd_q, status_q, enable_q, rd_word;
  logic [CFG_N-1:0] cfg_sel;
  logic [CFG_N*DW-1:0] cfg_q;

  assign sr_start = wr_en && (wr_addr == A_CMD) && wr_data[CMD_SRST] && !busy;
  assign clr      = sr_start || busy;
  assign wr_ok    = wr_en && !clr;

  mac_srst_seq #(.CYCLES(SRST_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(sr_start), .busy(busy)
  );

  mac_isr_status #(.DW(DW), .MASK(EVT_MASK)) u_isr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .evt(evt_pulse),
    .st_we(wr_ok && (wr_addr == A_IST)),
    .en_we(wr_ok && (wr_addr == A_IEN)),
    .wr_data(wr_data), .status_q(status_q), .enable_q(enable_q),
    .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  always_comb begin
    for (int i = 0; i < CFG_N; i++)
      cfg_sel[i] = wr_ok && (wr_addr == AW'(CFG_BASE + i));
  end

  mac_cfg_bank #(.N(CFG_N), .DW(DW), .DEFAULTS(CFG_DEFAULTS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_sel(cfg_sel),
    .wr_data(wr_data), .q(cfg_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cmd_q <= '0;
    else if (clr)                        cmd_q <= '0;
    else if (wr_ok && wr_addr == A_CMD)  cmd_q <= wr_data & CMD_KEEP;
  end

  always_comb begin
    rd_word = '0;
    case (rd_addr)
      A_CMD:   rd_word = cmd_q;
      A_IEN:   rd_word = enable_q;
      A_IST:   rd_word = status_q;
      default: begin
        for (int i = 0; i < CFG_N; i++)
          if (rd_addr == AW'(CFG_BASE + i)) rd_word = cfg_q[i*DW +: DW];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_en)  rd_data <= clr ? '0 : rd_word;
  end

  assign dma_rst_req = busy;
  assign rx_on       = cmd_q[CMD_RXON];
  assign long_pkt_ok = cmd_q[CMD_LONG];
  assign tx_on       = cmd_q[CMD_TXON];
endmodule

// File: rtl/mac_irq_ctl_chk.sv
module mac_irq_ctl_chk
  import mac_irq_pkg::*;
#(
  parameter int unsigned SRST_CYCLES = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic [DW-1:0] evt_pulse,
  input logic [DW-1:0] status_q,
  input logic          irq_tx,
  input logic          irq_rx,
  input logic          dma_rst_req
);
  localparam int unsigned CW = $clog2(SRST_CYCLES + 2);
  logic [CW-1:0] run_cnt;
  logic          start_c;
  logic [DW-1:0] ev_m;

  assign start_c = wr_en && (wr_addr == A_CMD) && wr_data[CMD_SRST] && !dma_rst_req;
  assign ev_m    = evt_pulse & EVT_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_cnt <= '0;
    else if (dma_rst_req) run_cnt <= run_cnt + 1'b1;
    else                  run_cnt <= '0;
  end

  // R7
  srst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> dma_rst_req);
  // R7
  srst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_rst_req && run_cnt != 0) |-> run_cnt == CW'(SRST_CYCLES));
  // R7
  srst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rst_req |-> run_cnt < CW'(SRST_CYCLES));
  // R8
  srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rst_req |-> (!irq_tx && !irq_rx));
  // R8
  srst_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && dma_rst_req) |=> rd_data == '0);
  // R4
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_m != '0 && !dma_rst_req && !start_c) |=> ((status_q & $past(ev_m)) == $past(ev_m)));
endmodule

bind mac_irq_ctl mac_irq_ctl_chk #(.SRST_CYCLES(SRST_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .evt_pulse(evt_pulse), .status_q(status_q),
  .irq_tx(irq_tx), .irq_rx(irq_rx), .dma_rst_req(dma_rst_req)
);

// File: tb/mac_irq_ctl_bench.sv
module mac_irq_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SR = 16;
  localparam logic [31:0] VMASK = 32'h0185_0F19;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, evt = '0;
  logic [31:0] rd_data;
  logic irq_tx, irq_rx, dma_rst_req, rx_on, long_pkt_ok, tx_on;

  int tests = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_irq_ctl u_mac_irq_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .evt_pulse(evt),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .dma_rst_req(dma_rst_req),
    .rx_on(rx_on), .long_pkt_ok(long_pkt_ok), .tx_on(tx_on)
  );

  // reference model
  logic [31:0] m_cmd, m_en, m_st, m_rd;
  logic [31:0] m_cfg [6];
  int m_cnt;

  function automatic logic [31:0] cfg_def(int i);
    case (i)
      0, 1: return 32'hFFFF_FFFC;
      2: return 32'h0000_0101;
      3: return 32'h0000_0800;
      4: return 32'h0000_7FFF;
      default: return 32'h0090_0000;
    endcase
  endfunction

  function automatic logic [31:0] m_read(logic [3:0] a);
    if (a == 0) return m_cmd;
    if (a == 1) return m_en;
    if (a == 2) return m_st;
    if (a >= 3 && a <= 8) return m_cfg[a-3];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cmd = 0; m_en = 0; m_st = 0; m_rd = 0; m_cnt = 0;
      for (int i = 0; i < 6; i++) m_cfg[i] = cfg_def(i);
    end else begin
      bit start;
      start = wr_en && wr_addr == 0 && wr_data[24] && m_cnt == 0;
      if (rd_en) m_rd = (start || m_cnt != 0) ? 32'h0 : m_read(rd_addr);
      if (start || m_cnt != 0) begin
        m_cmd = 0; m_en = 0; m_st = 0;
        for (int i = 0; i < 6; i++) m_cfg[i] = cfg_def(i);
        m_cnt = start ? SR : m_cnt - 1;
      end else begin
        logic [31:0] clrm;
        clrm = (wr_en && wr_addr == 2) ? wr_data : 32'h0;
        if (wr_en && wr_addr == 0) m_cmd = wr_data & ~(32'd1 << 24);
        if (wr_en && wr_addr == 1) m_en = wr_data;
        if (wr_en && wr_addr >= 3 && wr_addr <= 8) m_cfg[wr_addr-3] = wr_data;
        m_st = (m_st & ~clrm) | (evt & VMASK);
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("R6 rd_data", rd_data, m_rd);
      check("R5 irq_tx", {31'b0, irq_tx}, {31'b0, |(m_st[31:16] & m_en[31:16])});
      check("R5 irq_rx", {31'b0, irq_rx}, {31'b0, |(m_st[15:0] & m_en[15:0])});
      check("R7 dma_rst_req", {31'b0, dma_rst_req}, {31'b0, m_cnt != 0});
      check("R10 cmd outputs", {29'b0, rx_on, long_pkt_ok, tx_on},
            {29'b0, m_cmd[0], m_cmd[1], m_cmd[8]});
    end
    if (cycles > 20000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic pulse(logic [31:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = 0;
  endtask

  task automatic check_defaults(string req);
    logic [31:0] d;
    rd(0, d); check(req, d, 32'h0);
    rd(1, d); check(req, d, 32'h0);
    rd(2, d); check(req, d, 32'h0);
    rd(3, d); check(req, d, 32'hFFFF_FFFC);
    rd(4, d); check(req, d, 32'hFFFF_FFFC);
    rd(5, d); check(req, d, 32'h0000_0101);
    rd(6, d); check(req, d, 32'h0000_0800);
    rd(7, d); check(req, d, 32'h0000_7FFF);
    rd(8, d); check(req, d, 32'h0090_0000);
  endtask

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 defaults after hardware reset
    check_defaults("R1");
    // R6 unmapped words
    rd(9, d);  check("R6 unmapped", d, 0);
    rd(15, d); check("R6 unmapped", d, 0);

    // R2 all event positions, only implemented bits stick
    pulse(32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    rd(2, d); check("R2 sticky mask", d, VMASK);
    check("R5 no enable no irq", {30'b0, irq_tx, irq_rx}, 0);

    // R3 upper half clear only
    wr(2, 32'hFFFF_0000);
    rd(2, d); check("R3 tx half cleared", d, VMASK & 32'h0000_FFFF);
    wr(2, 32'h0000_0010);
    rd(2, d); check("R3 single bit", d, VMASK & 32'h0000_FFEF);
    wr(2, 32'hFFFF_FFFF);
    rd(2, d); check("R3 all clear", d, 0);

    // R5 enables and irq lines
    wr(1, 32'h0004_0010);
    rd(1, d); check("R5 enable rw", d, 32'h0004_0010);
    pulse(32'd1 << 16);
    check("R5 tx masked", {31'b0, irq_tx}, 0);
    pulse(32'd1 << 18);
    check("R5 tx asserted", {31'b0, irq_tx}, 1);
    check("R5 rx quiet", {31'b0, irq_rx}, 0);
    pulse(32'd1 << 4);
    check("R5 rx asserted", {31'b0, irq_rx}, 1);
    wr(2, 32'hFFFF_0000);
    check("R5 tx dropped", {31'b0, irq_tx}, 0);
    check("R5 rx kept", {31'b0, irq_rx}, 1);

    // R4 event and W1C in the same cycle
    @(negedge clk); wr_en = 1; wr_addr = 2; wr_data = 32'h0000_0010; evt = 32'h0000_0010;
    @(negedge clk); wr_en = 0; evt = 0;
    rd(2, d); check("R4 event wins", d & 32'h10, 32'h10);

    // R10 / R11 command and config
    wr(0, 32'h0000_0103);
    check("R10 rx_on", {31'b0, rx_on}, 1);
    check("R10 long_pkt_ok", {31'b0, long_pkt_ok}, 1);
    check("R10 tx_on", {31'b0, tx_on}, 1);
    wr(5, 32'h1234_5678);
    rd(5, d); check("R11 cfg rw", d, 32'h1234_5678);
    wr(8, 32'hCAFE_0001);
    rd(8, d); check("R11 cfg rw", d, 32'hCAFE_0001);

    // R7 duration
    wr(0, 32'h0100_0001);
    n = 0;
    while (dma_rst_req && n < 100) begin n++; @(negedge clk); end
    check("R7 reset cycles", n, SR);

    // R9 defaults after soft reset
    check_defaults("R9");

    // R8 activity during reset is ignored
    wr(3, 32'h5555_0000);
    wr(1, 32'hFFFF_FFFF);
    pulse(32'hFFFF_FFFF);
    wr(0, 32'h0100_0000);
    check("R7 req high", {31'b0, dma_rst_req}, 1);
    wr(3, 32'hAAAA_0000);
    wr(1, 32'hFFFF_FFFF);
    pulse(VMASK);
    check("R8 irq low", {30'b0, irq_tx, irq_rx}, 0);
    rd(3, d); check("R8 read zero", d, 0);
    rd(7, d); check("R8 read zero", d, 0);
    while (dma_rst_req) @(negedge clk);
    rd(3, d); check("R8 write ignored", d, 32'hFFFF_FFFC);
    rd(1, d); check("R8 enable untouched", d, 0);
    rd(2, d); check("R8 events ignored", d, 0);
    rd(0, d); check("R9 srst bit clear", d, 0);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule